// File: doc/BRIEF.md
# Shared Multi-Core Compare Timer

This block is one timer that several cores share. It holds a single counter that runs freely and, for each core, a compare register and a level interrupt line. The counter stays frozen after reset until software clears a stop bit in the configuration word. From then on it advances by one on every clock and wraps at its configured width. The width is 32 plus four times a parameter, and software can read that parameter back from the configuration word.

All access goes through one 32-bit register port. Each access carries the index of the core that makes the request. A local compare address always reaches the compare of the requesting core. A core can program the compare of another core in two steps. It first writes a target index into its own select register. It then uses a second pair of compare addresses, which reach the compare of that target core. The counter is read as a low word and a high word, and the port does not latch one word when the other is read. A core's interrupt goes high on the clock at which the counter steps onto that core's compare value. It stays high until software writes that core's compare again.

Top module: `shared_core_timer`

## Requirements
- R1: After reset the counter is 0, every compare is 0, every `irq_o` bit is 0, the stop bit is 1, and every select register is 0.
- R2: While the stop bit is 1, the counter keeps its value on every clock.
- R3: While the stop bit is 0, the counter rises by exactly 1 per clock and wraps at 32+4*COUNTBITS bits. Address 1 reads counter bits [31:0]. Address 2 reads the bits above 31, with zeros above the counter width.
- R4: Address 0 is the configuration word. Bit 0 is the stop bit, which can be read and written. Bits [11:8] read COUNTBITS and ignore writes. All other bits read 0. Writing 0 to bit 0 starts the counter from the next clock.
- R5: A core's interrupt becomes pending on the clock at which the running counter steps to a value equal to that core's compare. `irq_o[i]` is the level of core i's pending flag.
- R6: A pending interrupt stays asserted until that core's compare is written. A compare value that the counter has already passed does not fire until the counter wraps.
- R7: Any write to either word of a core's compare clears that core's pending flag, including a write of the value already held. A write wins over a match on the same clock.
- R8: Addresses 3 (low word) and 4 (high word) reach the compare of the requesting core `acc_core`. Accesses from a core index of NCORES or above are ignored and read 0.
- R9: Address 5 is a 3-bit select register, one per requesting core. Addresses 6 (low) and 7 (high) reach the compare of the core named in the requester's own select register.
- R10: If the requester's select register names a core index of NCORES or above, writes to addresses 6 and 7 change no compare, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid | input | 1 | Register access valid this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_core | input | 3 | Index of the requesting core |
| acc_addr | input | 3 | Word address of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from the address; 0 when no valid read |
| irq_o | output | NCORES | Level timer interrupt, one bit per core |

## Verification
The counter is programmed while stopped. Four compares are then set at different distances: a near one, a far one, one whose only set bit is in the high word, and one still at zero. After the counter starts, the bench samples each interrupt on the cycle before its match and on the cycle of the match. This tells an early or late match apart from a correct one, and shows that a compare which differs only in the high word does not fire. Pending flags are then cleared twice: once by rewriting the same value through the local address, and once by rewriting through the window from another core. These cases check stickiness, clearing and cross-core routing. The remaining checks cover an absent window target, per-requester select registers, and the counter stopping and restarting.

// File: rtl/scm_pkg.sv
package scm_pkg;

  typedef enum logic [2:0] {
    A_CFG     = 3'd0,
    A_CNT_LO  = 3'd1,
    A_CNT_HI  = 3'd2,
    A_LCMP_LO = 3'd3,
    A_LCMP_HI = 3'd4,
    A_OSEL    = 3'd5,
    A_OCMP_LO = 3'd6,
    A_OCMP_HI = 3'd7
  } reg_addr_e;

  localparam int STOP_BIT  = 0;
  localparam int WIDTH_LSB = 8;
  localparam int SEL_W     = 3;

endpackage

// File: rtl/scm_counter.sv
module scm_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_i,
  output logic          adv_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !stop_i;
    cnt_d  = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign adv_o     = cnt_en;
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> $stable(cnt_q));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |=> cnt_q == $past(cnt_q) + CW'(1));

endmodule

// File: rtl/scm_compare.sv
module scm_compare #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [31:0]   wdata_i,
  output logic [CW-1:0] cmp_o,
  output logic          pend_o
);

  logic [CW-1:0] cmp_q, cmp_d;
  logic          pend_q, pend_d;
  logic          cmp_en;
  logic          hit;
  logic [63:0]   wide;
  logic          unused_wide;

  always_comb begin
    cmp_en = wr_lo_i | wr_hi_i;
    wide   = 64'(cmp_q);
    if (wr_lo_i) wide[31:0]  = wdata_i;
    if (wr_hi_i) wide[63:32] = wdata_i;
    cmp_d  = wide[CW-1:0];
    hit    = adv_i && (cnt_nxt_i == cmp_q);
    if (cmp_en) pend_d = 1'b0;
    else        pend_d = pend_q | hit;
  end

  assign unused_wide = ^wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_en) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;

  // R5
  pend_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> cnt_i == cmp_q);

  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr_lo_i && !wr_hi_i) |=> pend_q);

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i || wr_hi_i) |=> !pend_q);

endmodule

// File: rtl/scm_decode.sv
module scm_decode
  import scm_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int CBITS  = 8,
  parameter int CW     = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [2:0]                 acc_core,
  input  logic [2:0]                 acc_addr,
  input  logic [31:0]                acc_wdata,
  input  logic [CW-1:0]              cnt_i,
  input  logic [NCORES-1:0][CW-1:0]  cmp_i,
  output logic                       stop_o,
  output logic [NCORES-1:0]          wr_lo_o,
  output logic [NCORES-1:0]          wr_hi_o,
  output logic [31:0]                rdata_o
);

  localparam int IDX_W = (NCORES > 1) ? $clog2(NCORES) : 1;

  reg_addr_e        addr_e;
  logic             req_ok, oth_ok, wen;
  logic [IDX_W-1:0] core_idx, tgt_idx;
  logic [SEL_W-1:0] own_sel;
  logic [SEL_W-1:0] sel_q [NCORES];
  logic [SEL_W-1:0] sel_d [NCORES];
  logic             sel_en, stop_q, stop_d, stop_en;
  logic [63:0]      cnt64, loc64, oth64;
  logic             unused_wdata;

  assign unused_wdata = ^acc_wdata[31:SEL_W];

  always_comb begin
    addr_e   = reg_addr_e'(acc_addr);
    req_ok   = {1'b0, acc_core} < 4'(NCORES);
    core_idx = req_ok ? acc_core[IDX_W-1:0] : '0;
    own_sel  = sel_q[core_idx];
    oth_ok   = {1'b0, own_sel} < 4'(NCORES);
    tgt_idx  = oth_ok ? own_sel[IDX_W-1:0] : '0;
    wen      = acc_valid && acc_write && req_ok;
    stop_en  = wen && (addr_e == A_CFG);
    stop_d   = acc_wdata[STOP_BIT];
    sel_en   = wen && (addr_e == A_OSEL);
    for (int i = 0; i < NCORES; i++) sel_d[i] = sel_q[i];
    sel_d[core_idx] = acc_wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stop_q <= 1'b1;
    else if (stop_en) stop_q <= stop_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCORES; i++) sel_q[i] <= '0;
    end else if (sel_en) begin
      for (int i = 0; i < NCORES; i++) sel_q[i] <= sel_d[i];
    end
  end

  for (genvar g = 0; g < NCORES; g++) begin : g_strobe
    logic loc_hit, oth_hit;
    assign loc_hit    = (core_idx == IDX_W'(g));
    assign oth_hit    = oth_ok && (tgt_idx == IDX_W'(g));
    assign wr_lo_o[g] = wen && (((addr_e == A_LCMP_LO) && loc_hit) ||
                                ((addr_e == A_OCMP_LO) && oth_hit));
    assign wr_hi_o[g] = wen && (((addr_e == A_LCMP_HI) && loc_hit) ||
                                ((addr_e == A_OCMP_HI) && oth_hit));
  end

  always_comb begin
    cnt64   = 64'(cnt_i);
    loc64   = 64'(cmp_i[core_idx]);
    oth64   = oth_ok ? 64'(cmp_i[tgt_idx]) : 64'd0;
    rdata_o = '0;
    if (acc_valid && !acc_write && req_ok) begin
      unique case (addr_e)
        A_CFG:     rdata_o = {20'd0, 4'(CBITS), 7'd0, stop_q};
        A_CNT_LO:  rdata_o = cnt64[31:0];
        A_CNT_HI:  rdata_o = cnt64[63:32];
        A_LCMP_LO: rdata_o = loc64[31:0];
        A_LCMP_HI: rdata_o = loc64[63:32];
        A_OSEL:    rdata_o = {29'd0, own_sel};
        A_OCMP_LO: rdata_o = oth64[31:0];
        A_OCMP_HI: rdata_o = oth64[63:32];
        default:   rdata_o = '0;
      endcase
    end
  end

  assign stop_o = stop_q;

  // R4
  stop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && req_ok && acc_addr == 3'd0)
      |=> stop_o == $past(acc_wdata[0]));

  // R10
  absent_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && req_ok && !oth_ok && acc_addr[2:1] == 2'b11)
      |-> rdata_o == 32'd0);

  // R10
  absent_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oth_ok && acc_addr[2:1] == 2'b11 |-> (wr_lo_o | wr_hi_o) == '0);

endmodule

// File: rtl/shared_core_timer.sv
module shared_core_timer #(
  parameter int NCORES    = 4,
  parameter int COUNTBITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_core,
  input  logic [2:0]        acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic [NCORES-1:0] irq_o
);

  localparam int CW = 32 + 4 * COUNTBITS;

  logic [1:0]               rst_sync_q;
  logic                     rst_core_n;
  logic                     stop, adv;
  logic [CW-1:0]            cnt, cnt_nxt;
  logic [NCORES-1:0][CW-1:0] cmp;
  logic [NCORES-1:0]        wr_lo, wr_hi, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  scm_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .stop_i    (stop),
    .adv_o     (adv),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  scm_decode #(.NCORES(NCORES), .CBITS(COUNTBITS), .CW(CW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_core  (acc_core),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .cnt_i     (cnt),
    .cmp_i     (cmp),
    .stop_o    (stop),
    .wr_lo_o   (wr_lo),
    .wr_hi_o   (wr_hi),
    .rdata_o   (acc_rdata)
  );

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    scm_compare #(.CW(CW)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .adv_i     (adv),
      .cnt_i     (cnt),
      .cnt_nxt_i (cnt_nxt),
      .wr_lo_i   (wr_lo[g]),
      .wr_hi_i   (wr_hi[g]),
      .wdata_i   (acc_wdata),
      .cmp_o     (cmp[g]),
      .pend_o    (pend[g])
    );
  end

  assign irq_o = pend;

  // R1
  irq_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_core_n |-> irq_o == '0);

endmodule

// File: tb/shared_core_timer_test.sv
module shared_core_timer_test;

  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid, acc_write;
  logic [2:0]    acc_core, acc_addr;
  logic [31:0]   acc_wdata;
  logic [31:0]   acc_rdata;
  logic [NC-1:0] irq_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  shared_core_timer #(.NCORES(NC), .COUNTBITS(8)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_core(acc_core), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic bus_wr(input logic [2:0] core, input logic [2:0] addr, input logic [31:0] d);
    acc_valid = 1; acc_write = 1; acc_core = core; acc_addr = addr; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  // zero-time read between edges
  task automatic bus_rd(input logic [2:0] core, input logic [2:0] addr, output logic [31:0] d);
    acc_valid = 1; acc_write = 0; acc_core = core; acc_addr = addr;
    #1 d = acc_rdata;
    acc_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", 64'(irq_o), 0);
    bus_rd(0, 3'd1, v); chk("R1 cnt lo", 64'(v), 0);
    bus_rd(0, 3'd0, v); chk("R4 cfg reset", 64'(v), 64'h801);
    bus_rd(2, 3'd3, v); chk("R1 cmp", 64'(v), 0);
    bus_rd(1, 3'd5, v); chk("R1 sel", 64'(v), 0);
  endtask

  task automatic t_program;
    logic [31:0] v;
    bus_wr(0, 3'd3, 32'd10);                 // core0 local lo
    bus_wr(0, 3'd5, 32'd1);                  // core0 selects core1
    bus_wr(0, 3'd6, 32'd5);                  // core1 lo via window
    bus_wr(2, 3'd4, 32'd1);                  // core2 hi = 1
    bus_rd(1, 3'd3, v); chk("R9 window wrote core1", 64'(v), 5);
    bus_rd(2, 3'd4, v); chk("R8 local hi core2", 64'(v), 1);
    bus_rd(0, 3'd3, v); chk("R8 local lo core0", 64'(v), 10);
    bus_rd(5, 3'd3, v); chk("R8 absent requester", 64'(v), 0);
  endtask

  task automatic t_fire;
    logic [31:0] v;
    bus_wr(0, 3'd0, 32'd0);                  // clear stop
    bus_rd(0, 3'd0, v); chk("R4 cfg running", 64'(v), 64'h800);
    bus_rd(0, 3'd1, v); chk("R4 start next clock", 64'(v), 0);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 4)  chk("R5 core1 early", 64'(irq_o[1]), 0);
      if (k == 5)  chk("R5 core1 at match", 64'(irq_o[1]), 1);
      if (k == 9)  chk("R5 core0 early", 64'(irq_o[0]), 0);
      if (k == 10) chk("R5 core0 at match", 64'(irq_o[0]), 1);
    end
    bus_rd(0, 3'd1, v); chk("R3 count lo", 64'(v), 12);
    bus_rd(0, 3'd2, v); chk("R3 count hi", 64'(v), 0);
    chk("R5 high-word compare silent", 64'(irq_o[2]), 0);
    chk("R6 zero compare waits wrap", 64'(irq_o[3]), 0);
  endtask

  task automatic t_clear;
    repeat (5) @(negedge clk);
    chk("R6 sticky", 64'(irq_o[1:0]), 3);
    bus_wr(0, 3'd3, 32'd10);                 // same value
    chk("R7 same-value clears core0", 64'(irq_o[0]), 0);
    chk("R7 core1 untouched", 64'(irq_o[1]), 1);
    bus_wr(3, 3'd5, 32'd1);
    bus_wr(3, 3'd7, 32'd0);                  // core1 hi via window
    chk("R7 window write clears core1", 64'(irq_o[1]), 0);
    repeat (20) @(negedge clk);
    chk("R6 passed compare silent", 64'(irq_o[1:0]), 0);
  endtask

  task automatic t_stop;
    logic [31:0] a, b, c;
    bus_wr(1, 3'd0, 32'd1);
    bus_rd(0, 3'd1, a);
    repeat (6) @(negedge clk);
    bus_rd(0, 3'd1, b); chk("R2 held", 64'(b), 64'(a));
    bus_wr(1, 3'd0, 32'd0);
    repeat (7) @(negedge clk);
    bus_rd(0, 3'd1, c); chk("R3 restart step", 64'(c), 64'(a) + 7);
  endtask

  task automatic t_window;
    logic [31:0] v;
    bus_wr(0, 3'd5, 32'd7);
    bus_wr(0, 3'd6, 32'h55);
    bus_wr(0, 3'd7, 32'h66);
    bus_rd(0, 3'd6, v); chk("R10 absent read", 64'(v), 0);
    bus_rd(0, 3'd3, v); chk("R10 core0 kept", 64'(v), 10);
    bus_rd(1, 3'd3, v); chk("R10 core1 kept", 64'(v), 5);
    bus_rd(2, 3'd3, v); chk("R10 core2 kept", 64'(v), 0);
    bus_rd(3, 3'd4, v); chk("R10 core3 kept", 64'(v), 0);
    bus_rd(3, 3'd5, v); chk("R9 per-requester select", 64'(v), 1);
    bus_wr(0, 3'd5, 32'd2);
    bus_rd(0, 3'd7, v); chk("R9 window read core2 hi", 64'(v), 1);
  endtask

  initial begin
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_core = 0; acc_addr = 0; acc_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_program;
    t_fire;
    t_clear;
    t_stop;
    t_window;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule